// File: doc/BRIEF.md
# Register-Window Trap Entry Controller

This block handles trap entry and trap return for a 32-bit processor that uses register windows. It holds the current window pointer, the mask of invalid windows, the trap-enable bit, the supervisor bit and the saved supervisor bit, and it also holds the trap base register. On a trap it rotates to the previous window and spills the two program counters into fixed local slots of that window. It then builds the vector address and sends fetch to it. Besides external trap pulses, three commands can start a trap from inside the block: a return-from-trap that is not allowed, a return-from-trap that would underflow, and an illegal status write.

The controller has four states. In **IDLE** it accepts commands. **SAVE_PC** is the first write cycle, which stores the trapped PC. **SAVE_NPC** is the second write cycle, which stores the trapped next PC and issues the redirect. **HALT** is a sticky error state.

The transitions are:
- IDLE→SAVE_PC: a trap is accepted while traps are enabled.
- SAVE_PC→SAVE_NPC: always.
- SAVE_NPC→IDLE: always.
- IDLE→HALT: a trap is accepted while traps are disabled.
- HALT→HALT: always, until reset.
- IDLE→IDLE: a successful return, a status write, a mask write, a base write, or no command.

The register file and the instruction decode sit outside the block. The block only drives a window select, a slot index, write data and a write strobe.

Top module: `trap_window_ctrl`

## Requirements
- R1: After reset the window pointer is 0, traps are disabled, supervisor is 1, saved supervisor is 0, the invalid mask is 0, the trap base register reads 0, and neither the write strobe, the redirect nor the error flag is raised.
- R2: A trap accepted while the trap-enable bit is 0 moves the block to a halted state. From the edge that accepts it, the error flag stays high until reset. While halted, every command is ignored, and no register write and no redirect occur.
- R3: A trap accepted while the trap-enable bit is 1 does four things at the accepting edge: it clears trap-enable, sets the window pointer to (pointer − 1) modulo the window count, copies supervisor into saved supervisor, and sets supervisor to 1.
- R4: In the first cycle after a trap is accepted, the block writes the PC to slot 9 of the new window. In the next cycle it writes the next PC to slot 10 of the same window.
- R5: Trap entry places the 8-bit trap type in bits [11:4] of the trap base register. Bits [31:12] are kept, and bits [3:0] read as zero.
- R6: In the cycle of the slot-10 write, and only then, the redirect is valid for one cycle. The redirect PC equals the trap base register, and the redirect next PC equals that value plus 4.
- R7: A return-from-trap issued while trap-enable is 1 takes a trap with type 0x02 (illegal instruction).
- R8: A return-from-trap issued while trap-enable is 0 takes a trap with type 0x06 (window underflow) when the invalid-mask bit for window (pointer + 1) modulo the window count is set. This entry starts from the current window, so it never halts.
- R9: A return-from-trap issued while trap-enable is 0 with that mask bit clear sets trap-enable, advances the pointer to (pointer + 1) modulo the window count, and loads supervisor from saved supervisor.
- R10: A status write loads the 5-bit window field, trap-enable, supervisor and saved supervisor when the field is below the window count. Otherwise it loads nothing and takes a trap with type 0x02, or halts if trap-enable is 0.
- R11: In IDLE the commands rank as follows: trap request, then return-from-trap, then status write, then mask and base writes. Only the top-ranked command present takes effect. Commands that arrive in either save cycle are ignored.
- R12: A mask write replaces the invalid mask. A base write loads bits [31:12] of the trap base register and leaves the trap-type field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Single-cycle trap request |
| trap_type | input | 8 | Trap type number for trap_req |
| cur_pc | input | 32 | PC to save on a trap |
| cur_npc | input | 32 | Next PC to save on a trap |
| rett_req | input | 1 | Return-from-trap command |
| psr_wr | input | 1 | Status write strobe |
| psr_wr_cwp | input | 5 | Window field of the status write |
| psr_wr_et | input | 1 | Trap-enable value of the status write |
| psr_wr_s | input | 1 | Supervisor value of the status write |
| psr_wr_ps | input | 1 | Saved-supervisor value of the status write |
| wim_wr | input | 1 | Invalid-mask write strobe |
| wim_wr_data | input | 8 | New invalid mask |
| tbr_wr | input | 1 | Trap-base write strobe |
| tbr_wr_data | input | 32 | New trap base; only [31:12] used |
| cwp | output | 3 | Current window pointer |
| trap_en | output | 1 | Trap-enable bit |
| sup_mode | output | 1 | Supervisor bit |
| prev_sup | output | 1 | Saved supervisor bit |
| wim | output | 8 | Invalid-window mask |
| tbr | output | 32 | Trap base register |
| rf_we | output | 1 | Register-file write strobe |
| rf_win | output | 3 | Window selected for the write |
| rf_idx | output | 5 | Slot within the window |
| rf_wdata | output | 32 | Data written |
| redirect_valid | output | 1 | One-cycle fetch redirect |
| redirect_pc | output | 32 | New PC |
| redirect_npc | output | 32 | New next PC |
| error_halt | output | 1 | Sticky error state |

## Verification
Trap entry is swept over every start window and three trap types: a computed type, all ones and zero. This separates the decrement wraparound at window 0 from the type-field placement. A return is swept over every pair of start window and single invalid-mask bit, so only the window (pointer + 1) modulo the count can give an underflow, and an off-by-one or unmasked wrap shows up at once. The status write is tried with every value of its 5-bit window field, which fixes the legal/illegal boundary exactly at the window count. Commands are also combined in one cycle and injected during the save cycles, which tells the ranking apart from the save-phase blocking.

// File: rtl/twc_pkg.sv
package twc_pkg;

    typedef enum logic [1:0] {
        TWC_IDLE     = 2'd0,
        TWC_SAVE_PC  = 2'd1,
        TWC_SAVE_NPC = 2'd2,
        TWC_HALT     = 2'd3
    } twc_state_e;

    localparam logic [7:0] TT_ILLEGAL   = 8'h02;
    localparam logic [7:0] TT_UNDERFLOW = 8'h06;

endpackage

// File: rtl/twc_win_arith.sv
module twc_win_arith #(
    parameter int NWIN   = 8,
    parameter int CWPF_W = 5,
    localparam int CWP_W = $clog2(NWIN)
) (
    input  logic [CWP_W-1:0]  cur,
    input  logic [NWIN-1:0]   mask,
    input  logic [CWPF_W-1:0] wr_field,
    output logic [CWP_W-1:0]  dec,
    output logic [CWP_W-1:0]  inc,
    output logic              inc_marked,
    output logic              field_legal
);

    logic [NWIN-1:0] hit;

    // Power-of-two window count: wrap is plain truncation
    assign dec = cur - CWP_W'(1);
    assign inc = cur + CWP_W'(1);

    for (genvar i = 0; i < NWIN; i++) begin : g_hit
        assign hit[i] = (inc == CWP_W'(i)) && mask[i];
    end

    assign inc_marked  = |hit;
    assign field_legal = ({1'b0, wr_field} < (CWPF_W+1)'(NWIN));

endmodule

// File: rtl/twc_vec_gen.sv
module twc_vec_gen #(
    parameter int AW   = 32,
    parameter int TT_W = 8,
    localparam int TB_LO = TT_W + 4
) (
    input  logic [AW-1:TB_LO] base,
    input  logic [TT_W-1:0]   tt,
    output logic [AW-1:0]     vec_pc,
    output logic [AW-1:0]     vec_npc
);

    assign vec_pc  = {base, tt, 4'b0000};
    assign vec_npc = vec_pc + AW'(4);

endmodule

// File: rtl/trap_window_ctrl.sv
module trap_window_ctrl
    import twc_pkg::*;
#(
    parameter int NWIN     = 8,
    parameter int AW       = 32,
    parameter int TT_W     = 8,
    parameter int CWPF_W   = 5,
    parameter int RIDX_W   = 5,
    parameter int PC_SLOT  = 9,
    parameter int NPC_SLOT = 10,
    localparam int CWP_W   = $clog2(NWIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic [TT_W-1:0]   trap_type,
    input  logic [AW-1:0]     cur_pc,
    input  logic [AW-1:0]     cur_npc,
    input  logic              rett_req,
    input  logic              psr_wr,
    input  logic [CWPF_W-1:0] psr_wr_cwp,
    input  logic              psr_wr_et,
    input  logic              psr_wr_s,
    input  logic              psr_wr_ps,
    input  logic              wim_wr,
    input  logic [NWIN-1:0]   wim_wr_data,
    input  logic              tbr_wr,
    input  logic [AW-1:0]     tbr_wr_data,
    output logic [CWP_W-1:0]  cwp,
    output logic              trap_en,
    output logic              sup_mode,
    output logic              prev_sup,
    output logic [NWIN-1:0]   wim,
    output logic [AW-1:0]     tbr,
    output logic              rf_we,
    output logic [CWP_W-1:0]  rf_win,
    output logic [RIDX_W-1:0] rf_idx,
    output logic [AW-1:0]     rf_wdata,
    output logic              redirect_valid,
    output logic [AW-1:0]     redirect_pc,
    output logic [AW-1:0]     redirect_npc,
    output logic              error_halt
);

    localparam int TB_LO = TT_W + 4;

    twc_state_e          st_q, st_d;
    logic [CWP_W-1:0]    cwp_q, cwp_d;
    logic                et_q, et_d;
    logic                s_q, s_d;
    logic                ps_q, ps_d;
    logic [NWIN-1:0]     wim_q, wim_d;
    logic [AW-1:TB_LO]   base_q, base_d;
    logic [TT_W-1:0]     tt_q, tt_d;
    logic [AW-1:0]       pcs_q, pcs_d;
    logic [AW-1:0]       npcs_q, npcs_d;

    logic [CWP_W-1:0]    cwp_dec, cwp_inc;
    logic                inc_marked, field_legal;
    logic [AW-1:0]       vec_pc, vec_npc;

    // Decoded command for this cycle
    logic                ev_trap, ev_et;
    logic [TT_W-1:0]     ev_tt;
    logic                ev_rett_ok, ev_psr_ok, ev_wim, ev_tbr;

    logic                unused_tbr_lo;
    assign unused_tbr_lo = ^tbr_wr_data[TB_LO-1:0];

    twc_win_arith #(
        .NWIN   (NWIN),
        .CWPF_W (CWPF_W)
    ) u_win_arith (
        .cur         (cwp_q),
        .mask        (wim_q),
        .wr_field    (psr_wr_cwp),
        .dec         (cwp_dec),
        .inc         (cwp_inc),
        .inc_marked  (inc_marked),
        .field_legal (field_legal)
    );

    twc_vec_gen #(
        .AW   (AW),
        .TT_W (TT_W)
    ) u_vec_gen (
        .base    (base_q),
        .tt      (tt_q),
        .vec_pc  (vec_pc),
        .vec_npc (vec_npc)
    );

    // Command ranking: trap, return, status write, mask/base writes
    always_comb begin
        ev_trap    = 1'b0;
        ev_et      = 1'b0;
        ev_tt      = '0;
        ev_rett_ok = 1'b0;
        ev_psr_ok  = 1'b0;
        ev_wim     = 1'b0;
        ev_tbr     = 1'b0;
        if (st_q == TWC_IDLE) begin
            if (trap_req) begin
                ev_trap = 1'b1;
                ev_tt   = trap_type;
                ev_et   = et_q;
            end else if (rett_req) begin
                if (et_q) begin
                    ev_trap = 1'b1;
                    ev_tt   = TT_W'(TT_ILLEGAL);
                    ev_et   = 1'b1;
                end else if (inc_marked) begin
                    // Return sets enable before the underflow check
                    ev_trap = 1'b1;
                    ev_tt   = TT_W'(TT_UNDERFLOW);
                    ev_et   = 1'b1;
                end else begin
                    ev_rett_ok = 1'b1;
                end
            end else if (psr_wr) begin
                if (field_legal) begin
                    ev_psr_ok = 1'b1;
                end else begin
                    ev_trap = 1'b1;
                    ev_tt   = TT_W'(TT_ILLEGAL);
                    ev_et   = et_q;
                end
            end else begin
                ev_wim = wim_wr;
                ev_tbr = tbr_wr;
            end
        end
    end

    // Next state and architectural register updates
    always_comb begin
        st_d   = st_q;
        cwp_d  = cwp_q;
        et_d   = et_q;
        s_d    = s_q;
        ps_d   = ps_q;
        wim_d  = wim_q;
        base_d = base_q;
        tt_d   = tt_q;
        pcs_d  = pcs_q;
        npcs_d = npcs_q;
        unique case (st_q)
            TWC_IDLE: begin
                if (ev_trap) begin
                    if (!ev_et) begin
                        st_d = TWC_HALT;
                    end else begin
                        st_d   = TWC_SAVE_PC;
                        et_d   = 1'b0;
                        cwp_d  = cwp_dec;
                        ps_d   = s_q;
                        s_d    = 1'b1;
                        tt_d   = ev_tt;
                        pcs_d  = cur_pc;
                        npcs_d = cur_npc;
                    end
                end else if (ev_rett_ok) begin
                    et_d  = 1'b1;
                    cwp_d = cwp_inc;
                    s_d   = ps_q;
                end else if (ev_psr_ok) begin
                    cwp_d = psr_wr_cwp[CWP_W-1:0];
                    et_d  = psr_wr_et;
                    s_d   = psr_wr_s;
                    ps_d  = psr_wr_ps;
                end
                if (ev_wim) wim_d  = wim_wr_data;
                if (ev_tbr) base_d = tbr_wr_data[AW-1:TB_LO];
            end
            TWC_SAVE_PC:  st_d = TWC_SAVE_NPC;
            TWC_SAVE_NPC: st_d = TWC_IDLE;
            TWC_HALT:     st_d = TWC_HALT;
            default:      st_d = TWC_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= TWC_IDLE;
            cwp_q  <= '0;
            et_q   <= 1'b0;
            s_q    <= 1'b1;
            ps_q   <= 1'b0;
            wim_q  <= '0;
            base_q <= '0;
            tt_q   <= '0;
            pcs_q  <= '0;
            npcs_q <= '0;
        end else begin
            st_q   <= st_d;
            cwp_q  <= cwp_d;
            et_q   <= et_d;
            s_q    <= s_d;
            ps_q   <= ps_d;
            wim_q  <= wim_d;
            base_q <= base_d;
            tt_q   <= tt_d;
            pcs_q  <= pcs_d;
            npcs_q <= npcs_d;
        end
    end

    // Outputs per state
    always_comb begin
        rf_we          = 1'b0;
        rf_idx         = '0;
        rf_wdata       = '0;
        redirect_valid = 1'b0;
        error_halt     = 1'b0;
        unique case (st_q)
            TWC_IDLE: ;
            TWC_SAVE_PC: begin
                rf_we    = 1'b1;
                rf_idx   = RIDX_W'(PC_SLOT);
                rf_wdata = pcs_q;
            end
            TWC_SAVE_NPC: begin
                rf_we          = 1'b1;
                rf_idx         = RIDX_W'(NPC_SLOT);
                rf_wdata       = npcs_q;
                redirect_valid = 1'b1;
            end
            TWC_HALT: error_halt = 1'b1;
            default: ;
        endcase
    end

    assign rf_win       = cwp_q;
    assign redirect_pc  = redirect_valid ? vec_pc  : '0;
    assign redirect_npc = redirect_valid ? vec_npc : '0;
    assign cwp          = cwp_q;
    assign trap_en      = et_q;
    assign sup_mode     = s_q;
    assign prev_sup     = ps_q;
    assign wim          = wim_q;
    assign tbr          = {base_q, tt_q, 4'b0000};

endmodule

// File: rtl/twc_checker.sv
module twc_checker #(
    parameter int NWIN     = 8,
    parameter int AW       = 32,
    parameter int TT_W     = 8,
    parameter int RIDX_W   = 5,
    parameter int PC_SLOT  = 9,
    parameter int NPC_SLOT = 10,
    localparam int CWP_W   = $clog2(NWIN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trap_req,
    input logic              rett_req,
    input logic [CWP_W-1:0]  cwp,
    input logic              trap_en,
    input logic              sup_mode,
    input logic              prev_sup,
    input logic [NWIN-1:0]   wim,
    input logic [AW-1:0]     tbr,
    input logic              rf_we,
    input logic [CWP_W-1:0]  rf_win,
    input logic [RIDX_W-1:0] rf_idx,
    input logic              redirect_valid,
    input logic [AW-1:0]     redirect_pc,
    input logic [AW-1:0]     redirect_npc,
    input logic              error_halt
);

    logic             idle;
    logic [CWP_W-1:0] next_win;
    assign idle     = !rf_we && !error_halt;
    assign next_win = cwp + CWP_W'(1);

    a_r2_halt_entry: assert property (@(posedge clk) disable iff (!rst_n)
        idle && trap_req && !trap_en |=> error_halt);

    a_r2_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        error_halt |=> error_halt && !rf_we && !redirect_valid);

    a_r3_entry_state: assert property (@(posedge clk) disable iff (!rst_n)
        idle && trap_req && trap_en |=>
            !trap_en && sup_mode && (prev_sup == $past(sup_mode)) &&
            (cwp == CWP_W'($past(cwp) - 1)));

    a_r4_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we && (rf_idx == RIDX_W'(PC_SLOT)) |=>
            rf_we && (rf_idx == RIDX_W'(NPC_SLOT)) && (rf_win == $past(rf_win)));

    a_r5_tbr_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        tbr[3:0] == 4'h0);

    a_r6_redirect_target: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (redirect_pc == tbr) && (redirect_npc == tbr + AW'(4)));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid);

    a_r9_return_ok: assert property (@(posedge clk) disable iff (!rst_n)
        idle && !trap_req && rett_req && !trap_en && !wim[next_win] |=>
            trap_en && (cwp == CWP_W'($past(cwp) + 1)) && (sup_mode == $past(prev_sup)));

endmodule

bind trap_window_ctrl twc_checker #(
    .NWIN     (NWIN),
    .AW       (AW),
    .TT_W     (TT_W),
    .RIDX_W   (RIDX_W),
    .PC_SLOT  (PC_SLOT),
    .NPC_SLOT (NPC_SLOT)
) u_twc_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .trap_req       (trap_req),
    .rett_req       (rett_req),
    .cwp            (cwp),
    .trap_en        (trap_en),
    .sup_mode       (sup_mode),
    .prev_sup       (prev_sup),
    .wim            (wim),
    .tbr            (tbr),
    .rf_we          (rf_we),
    .rf_win         (rf_win),
    .rf_idx         (rf_idx),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .redirect_npc   (redirect_npc),
    .error_halt     (error_halt)
);

// File: tb/trap_window_ctrl_bench.sv
module trap_window_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        trap_req;
    logic [7:0]  trap_type;
    logic [31:0] cur_pc, cur_npc;
    logic        rett_req, psr_wr;
    logic [4:0]  psr_wr_cwp;
    logic        psr_wr_et, psr_wr_s, psr_wr_ps;
    logic        wim_wr;
    logic [7:0]  wim_wr_data;
    logic        tbr_wr;
    logic [31:0] tbr_wr_data;
    logic [2:0]  cwp;
    logic        trap_en, sup_mode, prev_sup;
    logic [7:0]  wim;
    logic [31:0] tbr;
    logic        rf_we;
    logic [2:0]  rf_win;
    logic [4:0]  rf_idx;
    logic [31:0] rf_wdata;
    logic        redirect_valid;
    logic [31:0] redirect_pc, redirect_npc;
    logic        error_halt;

    always #4 clk = ~clk;

    trap_window_ctrl u_trap_window_ctrl (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
        .cur_pc(cur_pc), .cur_npc(cur_npc), .rett_req(rett_req), .psr_wr(psr_wr),
        .psr_wr_cwp(psr_wr_cwp), .psr_wr_et(psr_wr_et), .psr_wr_s(psr_wr_s),
        .psr_wr_ps(psr_wr_ps), .wim_wr(wim_wr), .wim_wr_data(wim_wr_data),
        .tbr_wr(tbr_wr), .tbr_wr_data(tbr_wr_data), .cwp(cwp), .trap_en(trap_en),
        .sup_mode(sup_mode), .prev_sup(prev_sup), .wim(wim), .tbr(tbr),
        .rf_we(rf_we), .rf_win(rf_win), .rf_idx(rf_idx), .rf_wdata(rf_wdata),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .redirect_npc(redirect_npc), .error_halt(error_halt)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Reference model of the architectural state
    logic [2:0]  m_cwp;
    logic        m_et, m_s, m_ps;
    logic [7:0]  m_wim;
    logic [19:0] m_base;
    logic [7:0]  m_tt;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_inputs();
        trap_req = 0; trap_type = 0; cur_pc = 0; cur_npc = 0; rett_req = 0;
        psr_wr = 0; psr_wr_cwp = 0; psr_wr_et = 0; psr_wr_s = 0; psr_wr_ps = 0;
        wim_wr = 0; wim_wr_data = 0; tbr_wr = 0; tbr_wr_data = 0;
    endtask

    task automatic step();
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic check_regs(input string req);
        chk(req, "cwp", 32'(cwp), 32'(m_cwp));
        chk(req, "et", 32'(trap_en), 32'(m_et));
        chk(req, "s", 32'(sup_mode), 32'(m_s));
        chk(req, "ps", 32'(prev_sup), 32'(m_ps));
        chk(req, "wim", 32'(wim), 32'(m_wim));
        chk(req, "tbr", tbr, {m_base, m_tt, 4'h0});
    endtask

    task automatic set_psr(input logic [4:0] f, input logic e, input logic s, input logic p);
        psr_wr = 1; psr_wr_cwp = f; psr_wr_et = e; psr_wr_s = s; psr_wr_ps = p;
        step();
        m_cwp = f[2:0]; m_et = e; m_s = s; m_ps = p;
    endtask

    task automatic set_wim(input logic [7:0] v);
        wim_wr = 1; wim_wr_data = v;
        step();
        m_wim = v;
    endtask

    // Called one cycle after the accepting edge
    task automatic expect_entry(input string req, input logic [31:0] pc,
                                input logic [31:0] npc, input logic [7:0] tt);
        logic [31:0] vec;
        m_ps  = m_s;
        m_s   = 1'b1;
        m_et  = 1'b0;
        m_cwp = m_cwp - 3'd1;
        m_tt  = tt;
        vec   = {m_base, m_tt, 4'h0};
        check_regs(req);
        chk(req, "we1", 32'(rf_we), 1);
        chk(req, "idx1", 32'(rf_idx), 9);
        chk(req, "win1", 32'(rf_win), 32'(m_cwp));
        chk(req, "data1", rf_wdata, pc);
        chk(req, "rv1", 32'(redirect_valid), 0);
        step();
        chk(req, "idx2", 32'(rf_idx), 10);
        chk(req, "win2", 32'(rf_win), 32'(m_cwp));
        chk(req, "data2", rf_wdata, npc);
        chk(req, "rv2", 32'(redirect_valid), 1);
        chk(req, "rpc", redirect_pc, vec);
        chk(req, "rnpc", redirect_npc, vec + 32'd4);
        step();
        chk(req, "rv3", 32'(redirect_valid), 0);
        chk(req, "we3", 32'(rf_we), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_cwp = 0; m_et = 0; m_s = 1; m_ps = 0; m_wim = 0; m_base = 0; m_tt = 0;
        // R1 reset state
        check_regs("R1");
        chk("R1", "we", 32'(rf_we), 0);
        chk("R1", "rv", 32'(redirect_valid), 0);
        chk("R1", "halt", 32'(error_halt), 0);

        // R12 base and mask writes
        tbr_wr = 1; tbr_wr_data = 32'hABCDE123;
        step();
        m_base = 20'hABCDE;
        check_regs("R12");
        set_wim(8'h5A);
        check_regs("R12");
        set_wim(8'h00);

        // R3 R4 R5 R6 entry sweep, R9 return back
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 3; k++) begin
                logic [7:0] tt;
                logic [31:0] pc;
                tt = (k == 0) ? 8'(c * 29 + 3) : ((k == 1) ? 8'hFF : 8'h00);
                pc = 32'h1000 + 32'(c * 64 + k * 8);
                set_psr(5'(c), 1'b1, c[0], ~c[0]);
                check_regs("R10");
                trap_req = 1; trap_type = tt; cur_pc = pc; cur_npc = pc + 4;
                step();
                expect_entry("R3", pc, pc + 4, tt);
                rett_req = 1;
                step();
                m_et = 1; m_cwp = m_cwp + 3'd1; m_s = m_ps;
                check_regs("R9");
            end
        end

        // R8 R9 underflow sweep over window and mask bit
        for (int c = 0; c < 8; c++) begin
            for (int w = 0; w < 8; w++) begin
                set_wim(8'(1 << w));
                set_psr(5'(c), 1'b0, 1'b1, 1'b0);
                rett_req = 1; cur_pc = 32'h2000 + 32'(c * 8 + w); cur_npc = 32'h3000;
                step();
                if (w == (c + 1) % 8) begin
                    expect_entry("R8", 32'h2000 + 32'(c * 8 + w), 32'h3000, 8'h06);
                end else begin
                    m_et = 1; m_cwp = m_cwp + 3'd1; m_s = m_ps;
                    check_regs("R9");
                end
            end
        end
        set_wim(8'h00);

        // R7 return with traps enabled
        set_psr(5'd3, 1'b1, 1'b0, 1'b1);
        rett_req = 1; cur_pc = 32'h4444; cur_npc = 32'h4448;
        step();
        expect_entry("R7", 32'h4444, 32'h4448, 8'h02);

        // R10 status-write field sweep
        for (int f = 0; f < 32; f++) begin
            set_psr(5'd0, 1'b1, 1'b1, 1'b0);
            psr_wr = 1; psr_wr_cwp = 5'(f); psr_wr_et = 1; psr_wr_s = 0; psr_wr_ps = 1;
            cur_pc = 32'h5000 + 32'(f); cur_npc = 32'h6000;
            step();
            if (f < 8) begin
                m_cwp = 3'(f); m_et = 1; m_s = 0; m_ps = 1;
                check_regs("R10");
            end else begin
                expect_entry("R10", 32'h5000 + 32'(f), 32'h6000, 8'h02);
            end
        end

        // R11 ranking: trap over return and status write
        set_psr(5'd4, 1'b1, 1'b0, 1'b0);
        trap_req = 1; trap_type = 8'h33; cur_pc = 32'h7000; cur_npc = 32'h7004;
        rett_req = 1; psr_wr = 1; psr_wr_cwp = 5'd1;
        step();
        expect_entry("R11", 32'h7000, 32'h7004, 8'h33);
        // R11 return over status write
        rett_req = 1; psr_wr = 1; psr_wr_cwp = 5'd6; psr_wr_et = 0;
        step();
        m_et = 1; m_cwp = m_cwp + 3'd1; m_s = m_ps;
        check_regs("R11");
        // R11 status write over mask write
        psr_wr = 1; psr_wr_cwp = 5'd2; psr_wr_et = 1; psr_wr_s = 1; psr_wr_ps = 1;
        wim_wr = 1; wim_wr_data = 8'hFF;
        step();
        m_cwp = 2; m_et = 1; m_s = 1; m_ps = 1;
        check_regs("R11");
        // R11 commands during save cycles are ignored
        set_psr(5'd5, 1'b1, 1'b0, 1'b0);
        trap_req = 1; trap_type = 8'h44; cur_pc = 32'h8000; cur_npc = 32'h8004;
        step();
        rett_req = 1; psr_wr = 1; psr_wr_cwp = 5'd1; wim_wr = 1; wim_wr_data = 8'hFF;
        tbr_wr = 1; tbr_wr_data = 32'h12345000;
        step();
        trap_req = 1; trap_type = 8'h55;
        step();
        m_ps = 0; m_s = 1; m_et = 0; m_cwp = 3'd4; m_tt = 8'h44;
        check_regs("R11");
        chk("R11", "we", 32'(rf_we), 0);

        // R2 trap while disabled halts and stays halted
        trap_req = 1; trap_type = 8'h10;
        step();
        chk("R2", "halt", 32'(error_halt), 1);
        set_psr(5'd1, 1'b1, 1'b0, 1'b0);
        m_cwp = 3'd4; m_et = 0; m_s = 1; m_ps = 0;
        check_regs("R2");
        trap_req = 1; trap_type = 8'h20;
        step();
        for (int i = 0; i < 4; i++) begin
            chk("R2", "halt", 32'(error_halt), 1);
            chk("R2", "rv", 32'(redirect_valid), 0);
            chk("R2", "we", 32'(rf_we), 0);
            step();
        end
        check_regs("R2");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule